// File: doc/BRIEF.md
# Host Mailbox with Command Responder

This block sits between a host CPU and a secondary CPU as a small two-address mailbox. The host reaches it through an 8-bit register window. Address bit 0 picks the port. At offset 0 the host writes and reads data. At offset 1 the host writes commands and reads status.

Every data write, and the echo commands, put the written byte with bit 6 inverted into a transmit register and mark that register busy. The consumer side sees the transmit register on `tx_data_o` and frees it with `tx_ack_i`. Some command codes preload a reply byte for the host, either a zero diagnostic value or the setting of an 8-bit switch bank. Data writes can also wake the secondary CPU with a one-clock interrupt pulse. That pulse is enabled by a one-shot latch, and the secondary CPU re-arms the latch with `arm_i`.

After reset a post-reset flag is set. While it is set, each status read first copies a default input bus into the reply register. The first data read clears the flag.

Top module: `host_mailbox`

## Requirements
- R1: A host read takes effect at the clock edge where `rd_i` is high. `rdata_o` shows the result from that edge on. A read at offset 1 returns status: bit 0 is reply-ready, bit 1 is transmit-busy, and the other bits are 0. A read at offset 0 returns the reply register.
- R2: A write to offset 0 loads the transmit register with the written byte XOR 0x40 and sets transmit-busy.
- R3: Command 0x00 and command 0xF0 each load the transmit register with the command byte XOR 0x40 and set transmit-busy. The reply-ready bit is unchanged.
- R4: Command 0x01 loads the transmit register with 0x41 and sets transmit-busy. It also loads 0x00 into the reply register and sets reply-ready.
- R5: Command 0x02 loads the reply register from `sw_i` and sets reply-ready. The transmit register and transmit-busy are unchanged.
- R6: Command 0x03 and any other code not listed above change only the last-command register (`last_cmd_o`). Status and the transmit register stay as they were. Every command write updates `last_cmd_o`.
- R7: A read at offset 0 clears reply-ready and clears the post-reset flag.
- R8: While the post-reset flag is set, a read at offset 1 loads `dflt_i` into the reply register and does not change reply-ready. Once the flag is clear, status reads no longer touch the reply register.
- R9: A data write while the interrupt-enable latch is set drives `irq_o` high for exactly one clock, one cycle after the write, and clears the latch. A data write with the latch clear gives no pulse.
- R10: A cycle with `arm_i` high sets the interrupt-enable latch, unless a data write fires the interrupt in the same cycle.
- R11: `tx_ack_i` clears transmit-busy and leaves `tx_data_o` unchanged. A transmit load in the same cycle wins over the acknowledge. `tx_data_o` always shows the transmit register.
- R12: Reset (`rst_ni` low) clears status, the transmit register, the reply register, `last_cmd_o`, `irq_o`, `rdata_o` and the interrupt-enable latch, and sets the post-reset flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| addr_i | input | 1 | Port select: 0 data, 1 command/status |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered host read data |
| sw_i | input | 8 | Switch bank setting |
| dflt_i | input | 8 | Default reply source used after reset |
| tx_ack_i | input | 1 | Consumer has taken the transmit byte |
| tx_data_o | output | 8 | Transmit register |
| arm_i | input | 1 | Secondary CPU re-arms the interrupt latch |
| irq_o | output | 1 | One-clock interrupt pulse to the secondary CPU |
| last_cmd_o | output | 8 | Last command byte written |

## Verification
The interrupt-enable latch cannot be seen at the ports, and neither can the post-reset flag. Each is observed only through its effect.

The latch comes up clear. The bench therefore first sends a data write that must give no pulse. It then pulses `arm_i`, checks for a single pulse, and sends a second write that must stay silent.

The post-reset flag is shown by changing `dflt_i` after the first data read. A later status read followed by a data read must still return the old reply byte.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] CMD_ECHO_LO = 8'h00;
  localparam logic [7:0] CMD_DIAG    = 8'h01;
  localparam logic [7:0] CMD_SWITCH  = 8'h02;
  localparam logic [7:0] CMD_ECHO_HI = 8'hF0;

  typedef struct packed {
    logic ld_tx;
    logic ld_reply;
    logic reply_sw;
    logic set_ready;
  } act_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] ECHO_MASK = DW'(8'h40)
) (
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          data_wr_o,
  output logic          cmd_wr_o,
  output logic [DW-1:0] echo_o,
  output act_t          act_o
);
  assign data_wr_o = wr_i && !addr_i;
  assign cmd_wr_o  = wr_i && addr_i;
  assign echo_o    = wdata_i ^ ECHO_MASK;

  always_comb begin
    act_o = '0;
    if (data_wr_o) begin
      act_o.ld_tx = 1'b1;
    end else if (cmd_wr_o) begin
      unique case (wdata_i)
        DW'(CMD_ECHO_LO), DW'(CMD_ECHO_HI): act_o.ld_tx = 1'b1;
        DW'(CMD_DIAG): begin
          act_o.ld_tx     = 1'b1;
          act_o.ld_reply  = 1'b1;
          act_o.set_ready = 1'b1;
        end
        DW'(CMD_SWITCH): begin
          act_o.ld_reply  = 1'b1;
          act_o.reply_sw  = 1'b1;
          act_o.set_ready = 1'b1;
        end
        default: act_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_wr_i,
  input  logic arm_i,
  output logic irq_o
);
  logic en_q, irq_q;
  logic fire;

  assign fire  = data_wr_i && en_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)       en_q <= 1'b0;
      else if (arm_i) en_q <= 1'b1;
    end
  end

  // R9
  irq_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(data_wr_i));
  // R10
  arm_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !data_wr_i) |=> en_q);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] ECHO_MASK = DW'(8'h40)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] sw_i,
  input  logic [DW-1:0] dflt_i,
  input  logic          tx_ack_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          arm_i,
  output logic          irq_o,
  output logic [DW-1:0] last_cmd_o
);
  localparam int PadW = DW - 2;

  logic [DW-1:0] tx_q, reply_q, last_q, rdata_q, echo;
  logic          rdy_q, busy_q, post_rst_q;
  logic          data_wr, cmd_wr;
  act_t          act;
  logic [DW-1:0] status;

  assign status     = {{PadW{1'b0}}, busy_q, rdy_q};
  assign rdata_o    = rdata_q;
  assign tx_data_o  = tx_q;
  assign last_cmd_o = last_q;

  mbox_decode #(.DW(DW), .ECHO_MASK(ECHO_MASK)) u_dec (
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .data_wr_o(data_wr),
    .cmd_wr_o (cmd_wr),
    .echo_o   (echo),
    .act_o    (act)
  );

  mbox_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_wr_i(data_wr),
    .arm_i    (arm_i),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      reply_q    <= '0;
      last_q     <= '0;
      rdata_q    <= '0;
      rdy_q      <= 1'b0;
      busy_q     <= 1'b0;
      post_rst_q <= 1'b1;
    end else begin
      if (rd_i && !addr_i) begin
        rdata_q    <= reply_q;
        rdy_q      <= 1'b0;
        post_rst_q <= 1'b0;
      end else if (rd_i) begin
        rdata_q <= status;
        if (post_rst_q) reply_q <= dflt_i;
      end
      if (tx_ack_i) busy_q <= 1'b0;
      // later assignments win: loads override ack/read clears
      if (act.ld_tx) begin
        tx_q   <= echo;
        busy_q <= 1'b1;
      end
      if (act.ld_reply) reply_q <= act.reply_sw ? sw_i : '0;
      if (act.set_ready) rdy_q <= 1'b1;
      if (cmd_wr) last_q <= wdata_i;
    end
  end

  // R11
  ack_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack_i && !wr_i) |=> !busy_q && $stable(tx_q));
  // R4
  diag_reply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i == DW'(CMD_DIAG)) |=> rdy_q && reply_q == '0);
  // R7
  data_rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i && !wr_i) |=> !rdy_q && !post_rst_q);
  // R6
  other_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && !rd_i && !tx_ack_i && wdata_i == DW'(8'h03))
      |=> $stable(tx_q) && $stable(busy_q) && $stable(rdy_q));
endmodule

// File: tb/host_mailbox_test.sv
`timescale 1ns/1ps
module host_mailbox_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr = 0, rd = 0, addr = 0, tx_ack = 0, arm = 0;
  logic [7:0] wdata = 0, sw = 0, dflt = 0;
  logic [7:0] rdata, tx_data, last_cmd;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    string      req;
    int         sel;   // 0 rdata 1 tx_data 2 irq 3 last_cmd
    logic [7:0] exp;
  } item_t;
  item_t sb[$];
  event smp_ev;

  always #5 clk = ~clk;

  host_mailbox uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sw_i(sw), .dflt_i(dflt),
    .tx_ack_i(tx_ack), .tx_data_o(tx_data), .arm_i(arm), .irq_o(irq),
    .last_cmd_o(last_cmd)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return rdata;
      1: return tx_data;
      2: return {7'b0, irq};
      default: return last_cmd;
    endcase
  endfunction

  initial forever begin
    @(smp_ev);
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [7:0] exp);
    sb.push_back('{req, sel, exp});
  endtask

  task automatic sample();
    -> smp_ev;
    #1;
  endtask

  task automatic host_wr(logic a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic host_rd(logic a);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
  endtask

  task automatic ack();
    @(negedge clk); tx_ack = 1;
    @(negedge clk); tx_ack = 0;
  endtask

  task automatic chk_status(string req, logic [7:0] exp);
    host_rd(1); expect_v(req, 0, exp); sample();
  endtask

  task automatic chk_data(string req, logic [7:0] exp);
    host_rd(0); expect_v(req, 0, exp); sample();
  endtask

  initial begin
    dflt = 8'h5A;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12 reset state
    expect_v("R12 tx", 1, 8'h00);
    expect_v("R12 irq", 2, 8'h00);
    expect_v("R12 last_cmd", 3, 8'h00);
    expect_v("R12 rdata", 0, 8'h00);
    sample();
    chk_status("R1 R12 status after reset", 8'h00);
    // R8 status read loaded dflt while post-reset flag set
    chk_data("R8 reply from default", 8'h5A);
    dflt = 8'h33;
    chk_status("R7 status", 8'h00);
    chk_data("R7 flag cleared, no reload", 8'h5A);

    // R2 data write; R9 latch clear after reset
    host_wr(0, 8'h12);
    expect_v("R2 tx echo", 1, 8'h52);
    expect_v("R9 no irq when disarmed", 2, 8'h00);
    sample();
    chk_status("R2 busy", 8'h02);
    // R11 ack
    ack();
    expect_v("R11 tx kept", 1, 8'h52);
    sample();
    chk_status("R11 busy cleared", 8'h00);

    // R3
    host_wr(1, 8'h00);
    expect_v("R3 cmd00 echo", 1, 8'h40);
    expect_v("R6 last_cmd 00", 3, 8'h00);
    sample();
    chk_status("R3 cmd00 busy", 8'h02);
    ack();
    host_wr(1, 8'hF0);
    expect_v("R3 cmdF0 echo", 1, 8'hB0);
    expect_v("R6 last_cmd F0", 3, 8'hF0);
    sample();
    chk_status("R3 cmdF0 busy", 8'h02);
    ack();

    // R4
    host_wr(1, 8'h01);
    expect_v("R4 cmd01 echo", 1, 8'h41);
    sample();
    chk_status("R4 ready and busy", 8'h03);
    chk_data("R4 zero reply", 8'h00);
    chk_status("R7 ready cleared", 8'h02);
    ack();

    // R5
    sw = 8'hC7;
    host_wr(1, 8'h02);
    expect_v("R5 tx unchanged", 1, 8'h41);
    sample();
    chk_status("R5 ready only", 8'h01);
    chk_data("R5 switch reply", 8'hC7);

    // R6
    host_wr(1, 8'h03);
    expect_v("R6 last_cmd 03", 3, 8'h03);
    expect_v("R6 tx unchanged 03", 1, 8'h41);
    sample();
    chk_status("R6 status unchanged 03", 8'h00);
    host_wr(1, 8'h77);
    expect_v("R6 last_cmd 77", 3, 8'h77);
    expect_v("R6 tx unchanged 77", 1, 8'h41);
    sample();
    chk_status("R6 status unchanged 77", 8'h00);
    chk_data("R6 reply unchanged", 8'hC7);

    // R10 arm, R9 pulse
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    host_wr(0, 8'hAA);
    expect_v("R9 irq pulse", 2, 8'h01);
    expect_v("R2 tx echo AA", 1, 8'hEA);
    sample();
    @(negedge clk);
    expect_v("R9 irq one clock", 2, 8'h00);
    sample();
    host_wr(0, 8'h01);
    expect_v("R9 latch cleared", 2, 8'h00);
    sample();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    host_wr(0, 8'h02);
    expect_v("R10 rearmed", 2, 8'h01);
    sample();

    // R11 load wins over ack in same cycle
    @(negedge clk); wr = 1; addr = 0; wdata = 8'h07; tx_ack = 1;
    @(negedge clk); wr = 0; tx_ack = 0;
    expect_v("R11 load over ack tx", 1, 8'h47);
    sample();
    chk_status("R11 load over ack busy", 8'h02);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule